// File: doc/BRIEF.md
# Masked S-box Table with Background Re-masking

This block keeps two copies of a masked 8-bit substitution table in one dual-ported memory of 512 bytes. The cipher reads the active copy through the read port. A controller uses the write port to rebuild the other copy under a fresh random mask, one entry per clock. Each entry is Q(x) = S(x XOR L(m)) XOR m. Here S is the fixed byte substitution and L is a linear map over GF(2) given by a parameter matrix.

A rebuild pass starts by taking a mask byte from a valid/ready random stream. It then writes all 256 entries of the inactive copy and waits. Only after the pass is finished, and the cipher has pulsed `op_done` since the previous swap, does the controller exchange the two copies in a single swap cycle. The new mask then appears on `act_mask` for the cipher's mask-correction logic, and the next pass begins at once on the copy that just went idle.

Lookups use a valid/ready stream whose ready is always high, so the rebuild never stalls the cipher. Results come out one cycle later as a valid-only stream with no back-pressure: the consumer must take each result in the cycle it appears. The random stream follows the usual rules. A mask is taken on a cycle where `rnd_valid` and `rnd_ready` are both high, and the source must keep `rnd_data` steady while `rnd_valid` is high and the byte has not been taken.

Top module: `sbox_remask_engine`

## Requirements
- R1: While `rst_n` is low, `res_valid`, `rnd_ready`, `ctx_swap`, `table_ok` and `act_ctx` are 0, `act_mask` is 8'h00 and `lk_ready` is 1.
- R2: `lk_ready` is always 1. Each cycle with `lk_valid` high gives exactly one cycle with `res_valid` high on the next cycle. `res_valid` is never high without a lookup in the cycle before it.
- R3: The result for address x under active mask m is S(x ^ L(m)) ^ m. S is the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (0 maps to 0), followed by the affine step b = v ^ rotl1(v) ^ rotl2(v) ^ rotl3(v) ^ rotl4(v) ^ 8'h63, so S(00)=63, S(01)=7C and S(53)=ED. Bit i of L(m) is the parity of (L_MATRIX[8i+7:8i] & m).
- R4: `rnd_ready` is high only while the controller waits for a mask. A byte taken on a valid-and-ready cycle becomes the mask of a pass that writes the 256 inactive entries in 256 consecutive cycles, in increasing address order. If `op_done` has already been accepted, `ctx_swap` is high in the 258th cycle after the cycle in which the mask was taken.
- R5: A swap happens only once the pass has finished and an `op_done` pulse has been accepted since the previous swap. The first swap after reset needs no pulse. A pulse during the swap cycle is discarded. If the pass has already finished, `ctx_swap` is high two cycles after the `op_done` cycle. At the end of the swap cycle `act_ctx` inverts and `act_mask` takes the new mask. At all other times both hold.
- R6: A lookup in the swap cycle is answered from the old copy, under the old mask.
- R7: The write port only ever writes the inactive copy (address bit 8 differs from `act_ctx`). Lookups made during a pass are served every cycle and give correct results.
- R8: In the cycle after each swap, `rnd_ready` is high for the next mask, so the two copies alternate without end. `table_ok` rises at the first swap and then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup ready, always 1 |
| lk_addr | input | 8 | Lookup address x |
| res_valid | output | 1 | Result valid, one cycle after the lookup |
| res_data | output | 8 | Masked table entry Q(x) |
| op_done | input | 1 | One-cycle pulse: the current cipher operation is finished |
| rnd_valid | input | 1 | Random mask byte valid |
| rnd_ready | output | 1 | Controller is waiting for a mask byte |
| rnd_data | input | 8 | Random mask byte |
| act_mask | output | 8 | Mask of the active copy |
| act_ctx | output | 1 | Index of the active copy |
| ctx_swap | output | 1 | High during the swap cycle |
| table_ok | output | 1 | The active copy holds a complete table |

## Verification
The bench builds the block with L_MATRIX = 64'hC060_3018_0C06_0301, where bit i of L(m) is m_i ^ m_(i-1). With this matrix, an implementation that drops L, or that applies it in the wrong bit order, gives wrong entries for almost every mask; the identity default would hide both faults. The address width stays at 8, so an exhaustive sweep of all 256 inputs under each of about ten random masks fits easily in the run. Many of these sweeps overlap an active rebuild pass. Lookups run every cycle across each swap, which puts a lookup in every swap cycle. The bench also holds `op_done` back well past the end of a pass to show that no swap happens early.

// File: rtl/sbox_remask_pkg.sv
package sbox_remask_pkg;

  localparam int SB_W = 8;

  typedef logic [SB_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAW,
    ST_WRITE,
    ST_WAIT,
    ST_SWAP
  } scr_state_e;

  // GF(2^8) product, reduction polynomial x^8+x^4+x^3+x+1
  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SB_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[SB_W-1] ? ({sh[SB_W-2:0], 1'b0} ^ 8'h1B) : {sh[SB_W-2:0], 1'b0};
    end
    return acc;
  endfunction

  // a^254 is the inverse for a != 0 and yields 0 for a == 0
  function automatic byte_t gf_inv(byte_t a);
    byte_t p;
    byte_t r;
    p = a;
    r = 8'h01;
    for (int i = 1; i < SB_W; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic byte_t sbox_fwd(byte_t x);
    byte_t v;
    v = gf_inv(x);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/remask_qbox.sv
module remask_qbox
  import sbox_remask_pkg::*;
#(
  parameter logic [SB_W*SB_W-1:0] L_MATRIX = 64'h8040_2010_0804_0201
) (
  input  byte_t idx_i,
  input  byte_t mask_i,
  output byte_t q_o
);

  byte_t lin_m;

  // one parity row per output bit of the linear map
  for (genvar r = 0; r < SB_W; r++) begin : g_row
    assign lin_m[r] = ^(L_MATRIX[r*SB_W +: SB_W] & mask_i);
  end

  assign q_o = sbox_fwd(idx_i ^ lin_m) ^ mask_i;

endmodule

// File: rtl/remask_dpram.sv
module remask_dpram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) rd_data_o <= mem[rd_addr_i];
  end

endmodule

// File: rtl/remask_ctrl.sv
module remask_ctrl
  import sbox_remask_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_done_i,
  input  logic             rnd_valid_i,
  input  byte_t            rnd_data_i,
  output logic             rnd_ready_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output byte_t            new_mask_o,
  output logic             act_ctx_o,
  output byte_t            act_mask_o,
  output logic             swap_o,
  output logic             table_ok_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  scr_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  byte_t            new_mask_q;
  byte_t            act_mask_q;
  logic             act_ctx_q;
  logic             done_seen_q;
  logic             table_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      new_mask_q  <= '0;
      act_mask_q  <= '0;
      act_ctx_q   <= 1'b0;
      done_seen_q <= 1'b1;  // the first swap waits for no operation
      table_ok_q  <= 1'b0;
    end else begin
      if (state_q == ST_SWAP) done_seen_q <= 1'b0;
      else if (op_done_i)     done_seen_q <= 1'b1;

      case (state_q)
        ST_IDLE: state_q <= ST_DRAW;
        ST_DRAW: begin
          if (rnd_valid_i) begin
            new_mask_q <= rnd_data_i;
            idx_q      <= '0;
            state_q    <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (done_seen_q) state_q <= ST_SWAP;
        end
        ST_SWAP: begin
          act_ctx_q  <= ~act_ctx_q;
          act_mask_q <= new_mask_q;
          table_ok_q <= 1'b1;
          state_q    <= ST_DRAW;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rnd_ready_o = (state_q == ST_DRAW);
  assign wr_en_o     = (state_q == ST_WRITE);
  assign wr_idx_o    = idx_q;
  assign new_mask_o  = new_mask_q;
  assign act_ctx_o   = act_ctx_q;
  assign act_mask_o  = act_mask_q;
  assign swap_o      = (state_q == ST_SWAP);
  assign table_ok_o  = table_ok_q;

  // R4: a taken mask starts a pass at index 0 under that byte
  a_r4_pass_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_ready_o && rnd_valid_i) |=> (wr_en_o && idx_q == '0 && new_mask_q == $past(rnd_data_i)));

  // R4: one address per cycle, ascending, without gaps
  a_r4_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && idx_q != LAST_IDX) |=> (wr_en_o && idx_q == $past(idx_q) + 1'b1));

  // R5: the swap cycle follows a wait with a recorded completion
  a_r5_swap_gated: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |-> ($past(state_q) == ST_WAIT && $past(done_seen_q)));

  // R5: active copy and mask move only out of a swap cycle
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_o |=> ($stable(act_ctx_q) && $stable(act_mask_q)));

  // R8: a new mask is requested right after each swap
  a_r8_redraw: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |=> rnd_ready_o);

endmodule

// File: rtl/sbox_remask_engine.sv
module sbox_remask_engine
  import sbox_remask_pkg::*;
#(
  parameter logic [SB_W*SB_W-1:0] L_MATRIX = 64'h8040_2010_0804_0201
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [SB_W-1:0] lk_addr,
  output logic            res_valid,
  output logic [SB_W-1:0] res_data,
  input  logic            op_done,
  input  logic            rnd_valid,
  output logic            rnd_ready,
  input  logic [SB_W-1:0] rnd_data,
  output logic [SB_W-1:0] act_mask,
  output logic            act_ctx,
  output logic            ctx_swap,
  output logic            table_ok
);

  localparam int MEM_AW = SB_W + 1;

  logic              wr_en;
  logic [SB_W-1:0]   wr_idx;
  byte_t             new_mask;
  byte_t             wr_data;
  logic [MEM_AW-1:0] wr_addr;
  logic [MEM_AW-1:0] rd_addr;

  remask_ctrl #(.IDX_W(SB_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_done_i   (op_done),
    .rnd_valid_i (rnd_valid),
    .rnd_data_i  (rnd_data),
    .rnd_ready_o (rnd_ready),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .new_mask_o  (new_mask),
    .act_ctx_o   (act_ctx),
    .act_mask_o  (act_mask),
    .swap_o      (ctx_swap),
    .table_ok_o  (table_ok)
  );

  remask_qbox #(.L_MATRIX(L_MATRIX)) u_qbox (
    .idx_i  (wr_idx),
    .mask_i (new_mask),
    .q_o    (wr_data)
  );

  assign wr_addr = {~act_ctx, wr_idx};
  assign rd_addr = {act_ctx, lk_addr};

  remask_dpram #(.AW(MEM_AW), .DW(SB_W)) u_ram (
    .clk       (clk),
    .rd_en_i   (lk_valid),
    .rd_addr_i (rd_addr),
    .rd_data_o (res_data),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data)
  );

  assign lk_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= lk_valid;
  end

  // R7: the write port stays inside the idle copy
  a_r7_write_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr[MEM_AW-1] != act_ctx));

  // R2: each lookup answers on the next cycle
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  // R2: no result without a lookup
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);

  // R8: once complete, the active table stays complete
  a_r8_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    table_ok |=> table_ok);

endmodule

// File: tb/sbox_remask_engine_test.sv
`timescale 1ns/1ps
module sbox_remask_engine_test;

  localparam logic [63:0] L_TB = 64'hC060_3018_0C06_0301;
  localparam int SWAP_LAT = 258;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, lk_valid, lk_ready, res_valid, op_done;
  logic       rnd_valid, rnd_ready, act_ctx, ctx_swap, table_ok;
  logic [7:0] lk_addr, res_data, rnd_data, act_mask;

  sbox_remask_engine #(.L_MATRIX(L_TB)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_addr(lk_addr), .res_valid(res_valid), .res_data(res_data),
    .op_done(op_done), .rnd_valid(rnd_valid), .rnd_ready(rnd_ready),
    .rnd_data(rnd_data), .act_mask(act_mask), .act_ctx(act_ctx),
    .ctx_swap(ctx_swap), .table_ok(table_ok)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [7:0]  sb [256];
  logic [17:0] sb_q [$];   // {tag(2), x, expected}
  logic [7:0]  mask_q [$];
  bit   done_flag, swap_prev, hs_done, op_req, rnd_gap, rnd_taken;
  int   hs_cyc = -1000, swaps = 0, r6_hits = 0, lk_mode = 0, sweep_i = 0;
  logic [7:0]  pend_mask;
  logic        prev_ctx;
  logic [31:0] seed = 32'h1234_5678;

  task automatic rnd32(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  function automatic logic [7:0] gmul_ref(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[0]) p = p ^ a;
      a = a[7] ? ({a[6:0], 1'b0} ^ 8'h1B) : {a[6:0], 1'b0};
      b = b >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] lin_ref(logic [7:0] v);
    return v ^ {v[6:0], 1'b0};
  endfunction

  function automatic logic [7:0] q_ref(logic [7:0] x, logic [7:0] m);
    return sb[x ^ lin_ref(m)] ^ m;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor first, then drive the inputs for the coming edge
  task automatic cycle();
    logic [17:0] e;
    logic [31:0] r;
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) begin
      check(1'b0, "WATCHDOG", "run hung", cyc, WD_LIMIT);
      finish_run();
    end
    if (res_valid) begin
      if (sb_q.size() == 0) check(1'b0, "R2", "result without lookup", res_data, 0);
      else begin
        e = sb_q.pop_front();
        check(res_data == e[7:0], e[17] ? "R6" : (e[16] ? "R7" : "R3"),
              $sformatf("entry x=%02h", e[15:8]), res_data, e[7:0]);
      end
    end else if (sb_q.size() != 0) begin
      check(1'b0, "R2", "result missing", 0, sb_q.size());
      sb_q.delete();
    end
    if (!lk_ready) check(1'b0, "R7", "lookup stalled", lk_ready, 1);
    if (swap_prev) begin
      check(act_ctx != prev_ctx, "R5", "copy index inverts", act_ctx, !prev_ctx);
      check(act_mask == pend_mask, "R5", "active mask", act_mask, pend_mask);
      check(rnd_ready, "R8", "mask request after swap", rnd_ready, 1);
      check(table_ok, "R8", "table_ok after swap", table_ok, 1);
    end else if (act_ctx != prev_ctx) begin
      check(1'b0, "R5", "copy changed outside swap", act_ctx, prev_ctx);
    end
    prev_ctx  = act_ctx;
    swap_prev = ctx_swap;
    if (ctx_swap) begin
      check(done_flag, "R5", "swap without op_done", 0, 1);
      if (hs_done) check(cyc - hs_cyc == SWAP_LAT, "R4", "pass length", cyc - hs_cyc, SWAP_LAT);
      hs_done   = 1'b0;
      done_flag = 1'b0;
      swaps++;
      if (mask_q.size() == 0) begin
        check(1'b0, "R5", "swap without a taken mask", 0, 1);
        pend_mask = 8'h00;
      end else pend_mask = mask_q.pop_front();
    end
    // lookups
    lk_valid = 1'b0;
    if (table_ok && lk_mode == 1) begin
      lk_valid = 1'b1;
      lk_addr  = sweep_i[7:0];
      sweep_i++;
      if (sweep_i == 256) lk_mode = 0;
    end else if (table_ok && lk_mode == 2) begin
      rnd32(r);
      lk_valid = 1'b1;
      lk_addr  = r[7:0];
    end
    if (lk_valid) begin
      if (ctx_swap) r6_hits++;
      sb_q.push_back({ctx_swap, (cyc - hs_cyc) <= 256, lk_addr, q_ref(lk_addr, act_mask)});
    end
    // operation-done pulse, kept out of the swap cycle
    op_done = 1'b0;
    if (op_req && !ctx_swap) begin
      op_done   = 1'b1;
      done_flag = 1'b1;
      op_req    = 1'b0;
    end
    // mask stream: hold data while valid and not taken
    if (!rnd_valid || rnd_taken) begin
      rnd32(r);
      rnd_valid = rnd_gap ? (r[9:8] == 2'b00) : 1'b1;
      rnd_data  = r[7:0];
    end
    rnd_taken = rnd_valid && rnd_ready;
    if (rnd_taken) begin
      mask_q.push_back(rnd_data);
      hs_cyc  = cyc;
      hs_done = done_flag;
    end
  endtask

  initial begin
    logic [31:0] r;
    int t, s0;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, b;
      inv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (gmul_ref(x[7:0], y[7:0]) == 8'h01) inv = y[7:0];
      for (int i = 0; i < 8; i++)
        b[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
             ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sb[x] = b;
    end
    rst_n = 1'b0; lk_valid = 1'b0; lk_addr = 8'h00; op_done = 1'b0;
    rnd_valid = 1'b0; rnd_data = 8'h00; done_flag = 1'b1; prev_ctx = 1'b0;
    swap_prev = 1'b0; hs_done = 1'b0; op_req = 1'b0; rnd_gap = 1'b0; rnd_taken = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(res_valid == 1'b0, "R1", "res_valid in reset", res_valid, 0);
    check(rnd_ready == 1'b0, "R1", "rnd_ready in reset", rnd_ready, 0);
    check(ctx_swap == 1'b0,  "R1", "ctx_swap in reset", ctx_swap, 0);
    check(table_ok == 1'b0,  "R1", "table_ok in reset", table_ok, 0);
    check(act_ctx == 1'b0,   "R1", "act_ctx in reset", act_ctx, 0);
    check(act_mask == 8'h00, "R1", "act_mask in reset", act_mask, 0);
    check(lk_ready == 1'b1,  "R2", "lk_ready in reset", lk_ready, 1);
    rst_n = 1'b1;
    cycle();
    check(rnd_ready == 1'b1, "R4", "mask request after reset", rnd_ready, 1);
    while (!table_ok) cycle();   // first swap checked for 258-cycle pass
    check(swaps == 1, "R5", "first swap needs no op_done", swaps, 1);

    // exhaustive sweep while the next pass runs; op_done withheld
    lk_mode = 1; sweep_i = 0;
    repeat (556) cycle();
    check(swaps == 1, "R5", "no swap while operation pending", swaps, 1);
    op_req = 1'b1;
    cycle();
    t = cyc;
    while (swaps == 1) cycle();
    check(cyc - t == 2, "R5", "swap delay after op_done", cyc - t, 2);

    // several masks, gaps in the mask stream, lookups across swaps
    rnd_gap = 1'b1;
    for (int it = 0; it < 9; it++) begin
      lk_mode = 1; sweep_i = 0;
      repeat (256) cycle();
      lk_mode = 2;
      rnd32(r);
      repeat (int'(r[9:0] % 600)) cycle();
      op_req = 1'b1;
      s0 = swaps;
      while (swaps == s0) cycle();
    end
    repeat (3) cycle();
    lk_mode = 0;
    repeat (3) cycle();
    check(r6_hits > 0, "R6", "lookups issued in swap cycles", r6_hits, 1);
    check(swaps >= 11, "R8", "copies keep alternating", swaps, 11);
    finish_run();
  end

endmodule